// File: doc/BRIEF.md
# Snoop-Broadcast Coherence Sequencer

This block keeps the caches of a small cluster of masters (two to eight) coherent. It serves one request at a time. Each accepted request carries:

- the number of the master that issued it;
- a read/write flag, a clean-for-ownership flag and an atomic flag;
- a line address and one word of write data.

The sequencer sends a snoop on the address channel to every master except the one that issued the request. It then collects one response from each of those masters. From the responses it takes one of three paths:

- returns the line straight from a peer cache;
- reads it from memory through a single AXI-style master port;
- writes a dirty peer copy back to memory before it finishes.

Write requests always go to memory after any write-back. An atomic write also brings back one extra read beat, which is passed on to the initiator.

The block sits between the arbitration stage and the memory port. It does no address generation or arbitration of its own. A new request is taken only when the previous one has fully completed.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready_o` is 1 and every valid and ready output is 0. From the accepting edge until the final handshake of that request, `req_ready_o` stays 0.
- R2: Snoops go to every master whose index differs from `req_id_i`. The initiator's `ac_valid_o` bit is never raised.
- R3: The snoop kind is given by `ac_inval_o`:
  - 0 (read-for-sharing) for a read without the clean-for-ownership flag;
  - 1 (clean-and-invalidate) for a read with that flag, and for every write.
- R4: Each target's `ac_valid_o` bit stays high until that target accepts. `ac_addr_o` carries the request address. The response phase starts only after every target has accepted.
- R5: `cr_ready_o` is high for each target that has not yet responded. No memory, write or initiator activity starts until all targets have responded.
- R6: For a plain read, the line comes from the snoop data channel when two conditions hold:
  - at least one target sets `cr_data_i`;
  - no target sets `cr_error_i`.

  Exactly LINE_BEATS beats are taken from the lowest-index such master and forwarded to the initiator response channel. `rsp_last_o` marks the final beat, and the block then goes idle.
- R7: A plain read with no data, or with any error, issues an AR on the request address. The R beats are forwarded to the initiator until the beat with `r_last_i`.
- R8: On a clean-and-invalidate, a write-back happens when a target sets both `cr_data_i` and `cr_dirty_i`. It uses the lowest-index such master:
  - an AW on the request address;
  - LINE_BEATS W beats copied from that master's snoop data, with `w_last_o` on the final one;
  - then waiting for B.

  `cd_ready_o` is one-hot on that master.
- R9: A target that reports data without dirty causes no write-back.
- R10: A clean-for-ownership read finishes with one response beat, with data 0 and `rsp_last_o` = 1, after any write-back.
- R11: A write request sends an AW on the request address, then one W beat of the request data with `w_last_o` = 1, then waits for B. This follows any write-back.
- R12: For an atomic write, one R beat is forwarded after B, with `rsp_last_o` forced to 1 whatever `r_last_i` is. The atomic flag has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted (idle) |
| req_id_i | input | IW | Index of the initiating master |
| req_write_i | input | 1 | 1 = write request |
| req_clean_uniq_i | input | 1 | Clean-for-ownership read |
| req_atomic_i | input | 1 | Atomic write |
| req_addr_i | input | AW | Line address |
| req_wdata_i | input | DW | Write data word |
| rsp_valid_o | output | 1 | Response beat to initiator |
| rsp_ready_i | input | 1 | Initiator accepts beat |
| rsp_id_o | output | IW | Initiator index of the response |
| rsp_data_o | output | DW | Response data |
| rsp_last_o | output | 1 | Final response beat |
| ac_valid_o | output | N_MST | Per-master snoop request valid |
| ac_ready_i | input | N_MST | Per-master snoop accept |
| ac_addr_o | output | AW | Snoop address |
| ac_inval_o | output | 1 | 1 = clean-and-invalidate, 0 = read |
| cr_valid_i | input | N_MST | Per-master snoop response valid |
| cr_ready_o | output | N_MST | Per-master response accept |
| cr_data_i | input | N_MST | Response: data will follow |
| cr_dirty_i | input | N_MST | Response: line is dirty |
| cr_error_i | input | N_MST | Response: error |
| cd_valid_i | input | N_MST | Per-master snoop data valid |
| cd_ready_o | output | N_MST | Per-master snoop data accept |
| cd_data_i | input | N_MST*DW | Snoop data, master m in slice m |
| aw_valid_o | output | 1 | Memory write address valid |
| aw_ready_i | input | 1 | Memory write address accept |
| aw_addr_o | output | AW | Memory write address |
| w_valid_o | output | 1 | Memory write data valid |
| w_ready_i | input | 1 | Memory write data accept |
| w_data_o | output | DW | Memory write data |
| w_last_o | output | 1 | Final write beat |
| b_valid_i | input | 1 | Write response valid |
| b_ready_o | output | 1 | Write response accept |
| ar_valid_o | output | 1 | Memory read address valid |
| ar_ready_i | input | 1 | Memory read address accept |
| ar_addr_o | output | AW | Memory read address |
| r_valid_i | input | 1 | Memory read data valid |
| r_ready_o | output | 1 | Memory read data accept |
| r_data_i | input | DW | Memory read data |
| r_last_i | input | 1 | Final read beat |

## Verification
The bench targets snoop acceptance and responses that arrive one target at a time in staggered order. A design that advanced on the first accept, or on the first response, would raise AW, AR or a response beat too early. It also offers data from several peers at once. Picking the wrong peer shows up as data words tagged with the wrong master number, or as more than one `cd_ready_o` bit.

Other runs cover three cases:
- data reported alongside an error, which must still fall back to memory;
- a clean copy, which must not be written back;
- an atomic write whose extra beat arrives without `r_last_i`. A design that waited for the last flag would hang there, and the watchdog would catch it.

A per-cycle model of the busy interval catches any design that reopens `req_ready_o` early or snoops the initiator.

// File: rtl/coh_snoop_pkg.sv
package coh_snoop_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SNP_REQ,
      ST_SNP_RSP,
      ST_WB_AW,
      ST_WB_W,
      ST_WB_B,
      ST_CU_ACK,
      ST_SNP_DATA,
      ST_MEM_AR,
      ST_MEM_R,
      ST_FWD_AW,
      ST_FWD_W,
      ST_FWD_B
   } coh_state_e;

   typedef struct packed {
      logic write;
      logic clean_uniq;
      logic atomic;
   } coh_kind_t;

endpackage

// File: rtl/coh_hs_track.sv
// Tracks a per-lane handshake round over a target mask.
module coh_hs_track #(
   parameter int N_LANE = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              active_i,
   input  logic [N_LANE-1:0] target_i,
   input  logic [N_LANE-1:0] hs_i,
   output logic [N_LANE-1:0] pend_o,
   output logic              done_o
);

   logic [N_LANE-1:0] seen_q;
   logic [N_LANE-1:0] seen_next;

   assign seen_next = seen_q | hs_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= '0;
      end else if (clear_i) begin
         seen_q <= '0;
      end else if (active_i) begin
         seen_q <= seen_next;
      end
   end

   assign pend_o = active_i ? (target_i & ~seen_q) : '0;
   assign done_o = active_i && ((seen_next & target_i) == target_i);

endmodule

// File: rtl/coh_resp_latch.sv
// Accumulates the per-master snoop response flags of one round.
module coh_resp_latch #(
   parameter int N_LANE = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic [N_LANE-1:0] hs_i,
   input  logic [N_LANE-1:0] data_i,
   input  logic [N_LANE-1:0] dirty_i,
   input  logic [N_LANE-1:0] err_i,
   output logic [N_LANE-1:0] data_o,
   output logic [N_LANE-1:0] dirty_o,
   output logic [N_LANE-1:0] err_o
);

   logic [N_LANE-1:0] data_q, dirty_q, err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q  <= '0;
         dirty_q <= '0;
         err_q   <= '0;
      end else if (clear_i) begin
         data_q  <= '0;
         dirty_q <= '0;
         err_q   <= '0;
      end else begin
         data_q  <= data_o;
         dirty_q <= dirty_o;
         err_q   <= err_o;
      end
   end

   // Merged view includes the responses arriving in the current cycle.
   assign data_o  = data_q  | (hs_i & data_i);
   assign dirty_o = dirty_q | (hs_i & dirty_i);
   assign err_o   = err_q   | (hs_i & err_i);

endmodule

// File: rtl/coh_lowest_pick.sv
// Fixed priority: lowest set index wins.
module coh_lowest_pick #(
   parameter int N_LANE = 4,
   parameter int IW     = 2
) (
   input  logic [N_LANE-1:0] req_i,
   output logic [IW-1:0]     idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N_LANE - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/coh_seq.sv
// Transaction sequencer: one request from acceptance to completion.
module coh_seq
   import coh_snoop_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       req_fire_i,
   input  coh_kind_t  kind_i,
   input  logic       ac_done_i,
   input  logic       cr_done_i,
   input  logic       hit_ok_i,
   input  logic       wb_need_i,
   input  logic       aw_ready_i,
   input  logic       wb_done_i,
   input  logic       w_ready_i,
   input  logic       b_valid_i,
   input  logic       ar_ready_i,
   input  logic       r_done_i,
   input  logic       line_done_i,
   input  logic       rsp_ready_i,
   output coh_state_e state_o
);

   coh_state_e st_q, st_d;
   logic       inval;

   assign inval = kind_i.write | kind_i.clean_uniq;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (req_fire_i) st_d = ST_SNP_REQ;
         ST_SNP_REQ:  if (ac_done_i)  st_d = ST_SNP_RSP;
         ST_SNP_RSP: begin
            if (cr_done_i) begin
               if (inval) begin
                  if (wb_need_i)         st_d = ST_WB_AW;
                  else if (kind_i.write) st_d = ST_FWD_AW;
                  else                   st_d = ST_CU_ACK;
               end else begin
                  st_d = hit_ok_i ? ST_SNP_DATA : ST_MEM_AR;
               end
            end
         end
         ST_WB_AW:    if (aw_ready_i) st_d = ST_WB_W;
         ST_WB_W:     if (wb_done_i)  st_d = ST_WB_B;
         ST_WB_B:     if (b_valid_i)  st_d = kind_i.write ? ST_FWD_AW : ST_CU_ACK;
         ST_CU_ACK:   if (rsp_ready_i) st_d = ST_IDLE;
         ST_SNP_DATA: if (line_done_i) st_d = ST_IDLE;
         ST_MEM_AR:   if (ar_ready_i) st_d = ST_MEM_R;
         ST_MEM_R:    if (r_done_i)   st_d = ST_IDLE;
         ST_FWD_AW:   if (aw_ready_i) st_d = ST_FWD_W;
         ST_FWD_W:    if (w_ready_i)  st_d = ST_FWD_B;
         ST_FWD_B:    if (b_valid_i)  st_d = kind_i.atomic ? ST_MEM_R : ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   assign state_o = st_q;

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
   import coh_snoop_pkg::*;
#(
   parameter int N_MST      = 4,
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LINE_BEATS = 2,
   localparam int IW        = (N_MST > 1) ? $clog2(N_MST) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_valid_i,
   output logic                req_ready_o,
   input  logic [IW-1:0]       req_id_i,
   input  logic                req_write_i,
   input  logic                req_clean_uniq_i,
   input  logic                req_atomic_i,
   input  logic [AW-1:0]       req_addr_i,
   input  logic [DW-1:0]       req_wdata_i,
   output logic                rsp_valid_o,
   input  logic                rsp_ready_i,
   output logic [IW-1:0]       rsp_id_o,
   output logic [DW-1:0]       rsp_data_o,
   output logic                rsp_last_o,
   output logic [N_MST-1:0]    ac_valid_o,
   input  logic [N_MST-1:0]    ac_ready_i,
   output logic [AW-1:0]       ac_addr_o,
   output logic                ac_inval_o,
   input  logic [N_MST-1:0]    cr_valid_i,
   output logic [N_MST-1:0]    cr_ready_o,
   input  logic [N_MST-1:0]    cr_data_i,
   input  logic [N_MST-1:0]    cr_dirty_i,
   input  logic [N_MST-1:0]    cr_error_i,
   input  logic [N_MST-1:0]    cd_valid_i,
   output logic [N_MST-1:0]    cd_ready_o,
   input  logic [N_MST*DW-1:0] cd_data_i,
   output logic                aw_valid_o,
   input  logic                aw_ready_i,
   output logic [AW-1:0]       aw_addr_o,
   output logic                w_valid_o,
   input  logic                w_ready_i,
   output logic [DW-1:0]       w_data_o,
   output logic                w_last_o,
   input  logic                b_valid_i,
   output logic                b_ready_o,
   output logic                ar_valid_o,
   input  logic                ar_ready_i,
   output logic [AW-1:0]       ar_addr_o,
   input  logic                r_valid_i,
   output logic                r_ready_o,
   input  logic [DW-1:0]       r_data_i,
   input  logic                r_last_i
);

   localparam int BW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
   localparam logic [BW-1:0] LAST_BEAT = BW'(LINE_BEATS - 1);

   // Elaboration-time parameter checks
   if (N_MST < 2 || N_MST > 8) begin : g_bad_nmst
      $error("coh_snoop_ctrl: N_MST must lie in 2..8");
   end
   if (LINE_BEATS < 1) begin : g_bad_beats
      $error("coh_snoop_ctrl: LINE_BEATS must be at least 1");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("coh_snoop_ctrl: AW and DW must be positive");
   end

   coh_state_e        st;
   coh_kind_t         kind_q;
   logic [IW-1:0]     id_q;
   logic [AW-1:0]     addr_q;
   logic [DW-1:0]     wdata_q;
   logic [N_MST-1:0]  tgt_q, tgt_d;
   logic [IW-1:0]     sel_q, pick_idx;
   logic [BW-1:0]     beat_q;
   logic              req_fire;
   logic [N_MST-1:0]  ac_hs, cr_hs;
   logic              ac_done, cr_done;
   logic [N_MST-1:0]  data_m, dirty_m, err_m, wb_m, pick_src;
   logic              hit_ok, wb_need, line_last;
   logic              cd_sel_valid, cd_fire;
   logic [DW-1:0]     cd_sel_data;
   logic [N_MST-1:0]  sel_oh;
   logic              wb_done, line_done, r_done;

   assign req_ready_o = (st == ST_IDLE);
   assign req_fire    = req_valid_i & req_ready_o;

   // Target mask: every lane except the initiator
   for (genvar g = 0; g < N_MST; g++) begin : g_tgt
      assign tgt_d[g] = (req_id_i != IW'(g));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         kind_q  <= '0;
         id_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         tgt_q   <= '0;
      end else if (req_fire) begin
         kind_q.write      <= req_write_i;
         kind_q.clean_uniq <= req_clean_uniq_i & ~req_write_i;
         kind_q.atomic     <= req_atomic_i & req_write_i;
         id_q              <= req_id_i;
         addr_q            <= req_addr_i;
         wdata_q           <= req_wdata_i;
         tgt_q             <= tgt_d;
      end
   end

   // Snoop request round
   assign ac_hs = ac_valid_o & ac_ready_i;

   coh_hs_track #(.N_LANE(N_MST)) u_ac_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (req_fire),
      .active_i (st == ST_SNP_REQ),
      .target_i (tgt_q),
      .hs_i     (ac_hs),
      .pend_o   (ac_valid_o),
      .done_o   (ac_done)
   );

   assign ac_addr_o  = addr_q;
   assign ac_inval_o = kind_q.write | kind_q.clean_uniq;

   // Snoop response round
   assign cr_hs = cr_ready_o & cr_valid_i;

   coh_hs_track #(.N_LANE(N_MST)) u_cr_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (req_fire),
      .active_i (st == ST_SNP_RSP),
      .target_i (tgt_q),
      .hs_i     (cr_hs),
      .pend_o   (cr_ready_o),
      .done_o   (cr_done)
   );

   coh_resp_latch #(.N_LANE(N_MST)) u_resp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (req_fire),
      .hs_i    (cr_hs),
      .data_i  (cr_data_i),
      .dirty_i (cr_dirty_i),
      .err_i   (cr_error_i),
      .data_o  (data_m),
      .dirty_o (dirty_m),
      .err_o   (err_m)
   );

   assign wb_m     = data_m & dirty_m;
   assign hit_ok   = (|data_m) && !(|err_m);
   assign wb_need  = |wb_m;
   assign pick_src = (kind_q.write | kind_q.clean_uniq) ? wb_m : data_m;

   coh_lowest_pick #(.N_LANE(N_MST), .IW(IW)) u_pick (
      .req_i (pick_src),
      .idx_o (pick_idx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           sel_q <= '0;
      else if (st == ST_SNP_RSP && cr_done) sel_q <= pick_idx;
   end

   assign sel_oh       = {{(N_MST-1){1'b0}}, 1'b1} << sel_q;
   assign cd_sel_valid = |(cd_valid_i & sel_oh);
   assign cd_sel_data  = cd_data_i[int'(sel_q)*DW +: DW];
   assign line_last    = (beat_q == LAST_BEAT);
   assign cd_fire      = |(cd_valid_i & cd_ready_o);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       beat_q <= '0;
      else if (req_fire) beat_q <= '0;
      else if (cd_fire)  beat_q <= line_last ? '0 : beat_q + BW'(1);
   end

   // Output steering per state
   always_comb begin
      rsp_valid_o = 1'b0;
      rsp_data_o  = '0;
      rsp_last_o  = 1'b0;
      cd_ready_o  = '0;
      aw_valid_o  = 1'b0;
      w_valid_o   = 1'b0;
      w_data_o    = '0;
      w_last_o    = 1'b0;
      b_ready_o   = 1'b0;
      ar_valid_o  = 1'b0;
      r_ready_o   = 1'b0;
      unique case (st)
         ST_WB_AW, ST_FWD_AW: aw_valid_o = 1'b1;
         ST_WB_W: begin
            w_valid_o  = cd_sel_valid;
            w_data_o   = cd_sel_data;
            w_last_o   = line_last;
            cd_ready_o = w_ready_i ? sel_oh : '0;
         end
         ST_FWD_W: begin
            w_valid_o = 1'b1;
            w_data_o  = wdata_q;
            w_last_o  = 1'b1;
         end
         ST_WB_B, ST_FWD_B: b_ready_o = 1'b1;
         ST_CU_ACK: begin
            rsp_valid_o = 1'b1;
            rsp_last_o  = 1'b1;
         end
         ST_SNP_DATA: begin
            rsp_valid_o = cd_sel_valid;
            rsp_data_o  = cd_sel_data;
            rsp_last_o  = line_last;
            cd_ready_o  = rsp_ready_i ? sel_oh : '0;
         end
         ST_MEM_AR: ar_valid_o = 1'b1;
         ST_MEM_R: begin
            rsp_valid_o = r_valid_i;
            rsp_data_o  = r_data_i;
            rsp_last_o  = kind_q.atomic | r_last_i;
            r_ready_o   = rsp_ready_i;
         end
         default: ;
      endcase
   end

   assign rsp_id_o  = id_q;
   assign aw_addr_o = addr_q;
   assign ar_addr_o = addr_q;

   assign wb_done   = w_valid_o & w_ready_i & line_last;
   assign line_done = rsp_valid_o & rsp_ready_i & line_last;
   assign r_done    = r_valid_i & rsp_ready_i & (kind_q.atomic | r_last_i);

   coh_seq u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_fire_i  (req_fire),
      .kind_i      (kind_q),
      .ac_done_i   (ac_done),
      .cr_done_i   (cr_done),
      .hit_ok_i    (hit_ok),
      .wb_need_i   (wb_need),
      .aw_ready_i  (aw_ready_i),
      .wb_done_i   (wb_done),
      .w_ready_i   (w_ready_i),
      .b_valid_i   (b_valid_i),
      .ar_ready_i  (ar_ready_i),
      .r_done_i    (r_done),
      .line_done_i (line_done),
      .rsp_ready_i (rsp_ready_i),
      .state_o     (st)
   );

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk #(
   parameter int N_MST = 4,
   parameter int AW    = 32,
   parameter int IW    = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [IW-1:0]    init_id,
   input logic             req_ready_o,
   input logic [N_MST-1:0] ac_valid_o,
   input logic [N_MST-1:0] ac_ready_i,
   input logic             aw_valid_o,
   input logic             aw_ready_i,
   input logic [AW-1:0]    aw_addr_o,
   input logic             w_valid_o,
   input logic             ar_valid_o,
   input logic             rsp_valid_o,
   input logic [N_MST-1:0] cd_ready_o
);

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o |-> (ac_valid_o == '0 && !aw_valid_o && !w_valid_o && !ar_valid_o && !rsp_valid_o)); // R1

   AST_NO_SELF_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_ready_o |-> !ac_valid_o[init_id]); // R2

   AST_AC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ac_valid_o & ~ac_ready_i) != '0) |=>
         ((ac_valid_o & $past(ac_valid_o & ~ac_ready_i)) == $past(ac_valid_o & ~ac_ready_i))); // R4

   AST_SNOOP_BEFORE_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ac_valid_o != '0) |-> (!aw_valid_o && !ar_valid_o && !rsp_valid_o)); // R5

   AST_CD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(cd_ready_o)); // R8

   AST_AW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (aw_valid_o && !aw_ready_i) |=> (aw_valid_o && $stable(aw_addr_o))); // R11

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.N_MST(N_MST), .AW(AW), .IW(IW)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .init_id     (id_q),
   .req_ready_o (req_ready_o),
   .ac_valid_o  (ac_valid_o),
   .ac_ready_i  (ac_ready_i),
   .aw_valid_o  (aw_valid_o),
   .aw_ready_i  (aw_ready_i),
   .aw_addr_o   (aw_addr_o),
   .w_valid_o   (w_valid_o),
   .ar_valid_o  (ar_valid_o),
   .rsp_valid_o (rsp_valid_o),
   .cd_ready_o  (cd_ready_o)
);

// File: tb/coh_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_tb_top;
   localparam int N = 4, AWD = 32, DWD = 32, LB = 2, IWD = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             req_valid = 0, req_ready;
   logic [IWD-1:0]   req_id = '0;
   logic             req_write = 0, req_cu = 0, req_atomic = 0;
   logic [AWD-1:0]   req_addr = '0;
   logic [DWD-1:0]   req_wdata = '0;
   logic             rsp_valid, rsp_ready = 0, rsp_last;
   logic [IWD-1:0]   rsp_id;
   logic [DWD-1:0]   rsp_data;
   logic [N-1:0]     ac_valid, ac_ready = '0;
   logic [AWD-1:0]   ac_addr;
   logic             ac_inval;
   logic [N-1:0]     cr_valid = '0, cr_ready, cr_data = '0, cr_dirty = '0, cr_error = '0;
   logic [N-1:0]     cd_valid = '0, cd_ready;
   logic [N*DWD-1:0] cd_data = '0;
   logic             aw_valid, aw_ready = 0, w_valid, w_ready = 0, w_last;
   logic [AWD-1:0]   aw_addr, ar_addr;
   logic [DWD-1:0]   w_data;
   logic             b_valid = 0, b_ready, ar_valid, ar_ready = 0;
   logic             r_valid = 0, r_ready, r_last = 0;
   logic [DWD-1:0]   r_data = '0;

   int checks = 0, errors = 0;
   bit busy = 0;
   int init = 0;

   coh_snoop_ctrl #(.N_MST(N), .AW(AWD), .DW(DWD), .LINE_BEATS(LB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_id_i(req_id),
      .req_write_i(req_write), .req_clean_uniq_i(req_cu), .req_atomic_i(req_atomic),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_id_o(rsp_id),
      .rsp_data_o(rsp_data), .rsp_last_o(rsp_last),
      .ac_valid_o(ac_valid), .ac_ready_i(ac_ready), .ac_addr_o(ac_addr), .ac_inval_o(ac_inval),
      .cr_valid_i(cr_valid), .cr_ready_o(cr_ready), .cr_data_i(cr_data),
      .cr_dirty_i(cr_dirty), .cr_error_i(cr_error),
      .cd_valid_i(cd_valid), .cd_ready_o(cd_ready), .cd_data_i(cd_data),
      .aw_valid_o(aw_valid), .aw_ready_i(aw_ready), .aw_addr_o(aw_addr),
      .w_valid_o(w_valid), .w_ready_i(w_ready), .w_data_o(w_data), .w_last_o(w_last),
      .b_valid_i(b_valid), .b_ready_o(b_ready),
      .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_addr_o(ar_addr),
      .r_valid_i(r_valid), .r_ready_o(r_ready), .r_data_i(r_data), .r_last_i(r_last)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int lowest(logic [N-1:0] m);
      for (int i = 0; i < N; i++) if (m[i]) return i;
      return -1;
   endfunction

   function automatic logic [DWD-1:0] pat(int m, int b);
      return 32'hC000_0000 | (m << 8) | b;
   endfunction

   task automatic drive_cd(logic [N-1:0] m, int b);
      cd_valid = m;
      for (int k = 0; k < N; k++) cd_data[k*DWD +: DWD] = pat(k, b);
   endtask

   // Per-cycle model: busy interval and initiator exclusion
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 req_ready against model busy", req_ready, !busy);
         if (busy) chk("R2 initiator never snooped", ac_valid[init], 1'b0);
      end
   end

   task automatic do_txn(int id, bit wr, bit cu, bit at, logic [AWD-1:0] addr,
                         logic [DWD-1:0] wd, logic [N-1:0] d, logic [N-1:0] dy,
                         logic [N-1:0] er);
      logic [N-1:0] tgt, acked, rem, pick, dat;
      bit inval;
      int sel, g;
      tgt   = ~(4'b0001 << id) & 4'hF;
      inval = wr | cu;
      // request
      req_valid = 1; req_id = IWD'(id); req_write = wr; req_cu = cu;
      req_atomic = at; req_addr = addr; req_wdata = wd;
      tick();
      busy = 1; init = id;
      req_valid = 0;
      // snoop broadcast, one target accepted per cycle
      acked = '0; g = 0;
      while (acked != tgt && g < 20) begin
         #1;
         chk("R4 ac_valid pending targets", ac_valid, tgt & ~acked);
         chk("R3 ac_inval kind", ac_inval, inval);
         chk("R4 ac_addr", ac_addr, addr);
         rem  = tgt & ~acked;
         pick = rem & (~rem + 1'b1);
         ac_ready = pick;
         tick();
         acked |= pick; ac_ready = '0; g++;
      end
      // responses, one target per cycle from highest index
      rem = tgt; g = 0;
      while (rem != '0 && g < 20) begin
         #1;
         chk("R5 cr_ready pending", cr_ready, rem);
         chk("R5 no memory or response before all CR", {aw_valid, ar_valid, rsp_valid, w_valid}, 4'b0);
         pick = '0;
         for (int i = N - 1; i >= 0; i--) if (rem[i] && pick == '0) pick[i] = 1'b1;
         cr_valid = pick; cr_data = d & pick; cr_dirty = dy & pick; cr_error = er & pick;
         tick();
         rem &= ~pick; cr_valid = '0; cr_data = '0; cr_dirty = '0; cr_error = '0; g++;
      end
      dat = d & tgt;
      if (inval) begin
         if ((dat & dy) != '0) begin
            sel = lowest(dat & dy);
            #1;
            chk("R8 write-back AW valid", aw_valid, 1'b1);
            chk("R8 write-back AW addr", aw_addr, addr);
            tick();
            chk("R8 AW held while not ready", aw_valid, 1'b1);
            aw_ready = 1;
            tick();
            aw_ready = 0;
            for (int b = 0; b < LB; b++) begin
               drive_cd(dat, b); w_ready = 1;
               #1;
               chk("R8 write-back W valid", w_valid, 1'b1);
               chk("R8 write-back data from lowest dirty", w_data, pat(sel, b));
               chk("R8 write-back w_last", w_last, b == LB - 1);
               chk("R8 cd_ready one-hot on chosen", cd_ready, 4'b0001 << sel);
               tick();
            end
            cd_valid = '0; w_ready = 0;
            #1;
            chk("R8 b_ready during write-back", b_ready, 1'b1);
            b_valid = 1;
            tick();
            b_valid = 0;
         end else begin
            #1;
            chk("R9 no write-back for clean copy", {aw_valid, w_valid} & {!wr, 1'b1}, 2'b00);
         end
         if (!wr) begin
            #1;
            chk("R10 clean-unique ack valid", rsp_valid, 1'b1);
            chk("R10 clean-unique ack data", rsp_data, 0);
            chk("R10 clean-unique ack last", rsp_last, 1'b1);
            chk("R10 ack id", rsp_id, id);
            rsp_ready = 1;
            tick();
            rsp_ready = 0;
         end else begin
            #1;
            chk("R11 forward AW valid", aw_valid, 1'b1);
            chk("R11 forward AW addr", aw_addr, addr);
            aw_ready = 1;
            tick();
            aw_ready = 0; w_ready = 1;
            #1;
            chk("R11 forward W valid", w_valid, 1'b1);
            chk("R11 forward W data", w_data, wd);
            chk("R11 forward W last", w_last, 1'b1);
            tick();
            w_ready = 0; b_valid = 1;
            #1;
            chk("R11 forward b_ready", b_ready, 1'b1);
            tick();
            b_valid = 0;
            if (at) begin
               r_valid = 1; r_data = 32'hA70_0000 | id; r_last = 0; rsp_ready = 1;
               #1;
               chk("R12 atomic extra beat valid", rsp_valid, 1'b1);
               chk("R12 atomic extra beat data", rsp_data, 32'hA70_0000 | id);
               chk("R12 atomic beat last forced", rsp_last, 1'b1);
               tick();
               r_valid = 0; rsp_ready = 0;
            end
         end
      end else if (dat != '0 && (er & tgt) == '0) begin
         sel = lowest(dat);
         for (int b = 0; b < LB; b++) begin
            drive_cd(dat, b); rsp_ready = 1;
            #1;
            chk("R6 snoop data valid", rsp_valid, 1'b1);
            chk("R6 snoop data from lowest master", rsp_data, pat(sel, b));
            chk("R6 rsp_last on final beat", rsp_last, b == LB - 1);
            chk("R6 cd_ready one-hot", cd_ready, 4'b0001 << sel);
            chk("R6 no memory read on hit", ar_valid, 1'b0);
            tick();
         end
         cd_valid = '0; rsp_ready = 0;
      end else begin
         #1;
         chk("R7 AR valid on miss", ar_valid, 1'b1);
         chk("R7 AR addr", ar_addr, addr);
         ar_ready = 1;
         tick();
         ar_ready = 0;
         for (int b = 0; b < 3; b++) begin
            r_valid = 1; r_data = 32'hD000_0000 + b; r_last = (b == 2); rsp_ready = 1;
            #1;
            chk("R7 memory beat forwarded", rsp_data, 32'hD000_0000 + b);
            chk("R7 rsp_last follows r_last", rsp_last, b == 2);
            chk("R7 r_ready", r_ready, 1'b1);
            tick();
         end
         r_valid = 0; r_last = 0; rsp_ready = 0;
      end
      busy = 0;
      #1;
      chk("R1 idle after completion", req_ready, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      #1;
      chk("R1 reset req_ready", req_ready, 1'b1);
      chk("R1 reset ac_valid", ac_valid, 0);
      chk("R1 reset outputs quiet", {aw_valid, w_valid, ar_valid, rsp_valid, b_ready, r_ready}, 0);
      chk("R1 reset cr/cd ready", {cr_ready, cd_ready}, 0);
      tick();
      // R6 hit, two holders: lowest index (2) wins
      do_txn(0, 0, 0, 0, 32'h1000, 0, 4'b1100, 4'b0000, 4'b0000);
      // R7 miss: no data
      do_txn(1, 0, 0, 0, 32'h2040, 0, 4'b0000, 4'b0000, 4'b0000);
      // R7 data plus error elsewhere: memory
      do_txn(2, 0, 0, 0, 32'h3080, 0, 4'b0001, 4'b0000, 4'b1000);
      // R8 R10 clean-unique with two dirty holders, lowest (1) written back
      do_txn(3, 0, 1, 0, 32'h40C0, 0, 4'b0110, 4'b0110, 4'b0000);
      // R9 R10 clean-unique, clean copy only
      do_txn(0, 0, 1, 0, 32'h5100, 0, 4'b0010, 4'b0000, 4'b0000);
      // R11 plain write
      do_txn(1, 1, 0, 0, 32'h6140, 32'hBEEF_0001, 4'b0000, 4'b0000, 4'b0000);
      // R8 R11 write with dirty holder 0
      do_txn(2, 1, 0, 0, 32'h7180, 32'hBEEF_0002, 4'b1001, 4'b0001, 4'b0000);
      // R12 atomic write
      do_txn(3, 1, 0, 1, 32'h81C0, 32'hBEEF_0003, 4'b0000, 4'b0000, 4'b0000);
      // R12 atomic flag on a read has no effect: normal hit from master 0
      do_txn(3, 0, 0, 1, 32'h9200, 0, 4'b0011, 4'b0000, 4'b0000);
      // R9 write with clean holder: no write-back before forward
      do_txn(0, 1, 0, 0, 32'hA240, 32'hBEEF_0004, 4'b0100, 4'b0000, 4'b0000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule